// File: doc/BRIEF.md
# Redundant Fuse Program Sequencer

This block turns one logical fuse-programming request into the series of raw burn operations that a lower-level fuse controller carries out. A request names a logical word index and a 32-bit value. For indices that are guarded by redundancy, the block issues three raw burns of the same value. The two redundancy copies go first and the main word goes last, and all three run with ECC bypassed. Every other index gets a single burn at its own address with ECC applied.

The block accepts a request through a valid/ready port. It drives each raw operation with a one-cycle start strobe and holds address, data and the ECC-bypass flag steady until the controller returns a done pulse with an error flag. When the sequence ends, the block answers with a one-cycle response pulse that carries an error flag. An out-of-range index, or a failure on any raw step, ends the sequence early and sets that flag.

Top module: `fuse_burn_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `raw_start` and `rsp_valid` are 0.
- R2: The redundancy-guarded logical indices are 0..3 and 176..206. An accepted index of at most 199 outside those sets produces exactly one raw burn at address equal to the index, with `raw_ecc_bypass` = 0.
- R3: For a guarded index i below 4, the two redundancy copies go to raw addresses 200+2i and 201+2i.
- R4: For a guarded index i from 176 upward, the two redundancy copies go to raw addresses 208+2(i-176) and 209+2(i-176).
- R5: A guarded index produces exactly three raw burns in this order: first copy, second copy, main index. All three carry the request value and have `raw_ecc_bypass` = 1.
- R6: A request whose index is above 199 issues no raw burn, and `rsp_valid` is raised with `rsp_error` = 1 in the cycle after acceptance.
- R7: A raw done pulse with `raw_error` = 1 stops the sequence. No further `raw_start` follows, and the response carries `rsp_error` = 1.
- R8: `req_ready` is 0 from the cycle after acceptance until the response cycle has passed. A request held valid during that time is ignored.
- R9: The response is a single-cycle `rsp_valid` pulse in the cycle after the final raw done pulse, with `rsp_error` = 0 when every step succeeded.
- R10: `raw_addr`, `raw_data` and `raw_ecc_bypass` stay stable from a `raw_start` strobe until its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Logical program request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_index | input | 8 | Logical word index |
| req_data | input | 32 | Value to burn |
| raw_start | output | 1 | One-cycle strobe starting a raw burn |
| raw_addr | output | 8 | Raw fuse word address of the current burn |
| raw_data | output | 32 | Value of the current burn |
| raw_ecc_bypass | output | 1 | 1 = burn without ECC, 0 = controller applies ECC |
| raw_done | input | 1 | Controller finished the current burn |
| raw_error | input | 1 | Qualifies raw_done: the burn failed |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Qualifies rsp_valid: request failed |

## Verification
The hardest situation to reach is a failure on the second or third step of a guarded sequence. By then the redundancy copies are already burned, and the block must stop before it touches the main word. The bench plays the controller itself. It counts strobes and answers the chosen step with an error. This lets it abort at step zero, one or two of a three-burn sequence and confirm from the ports how many burns took place. The same model keeps a stray request held valid during every sequence to show that it is never taken.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } fbs_state_e;

endpackage

// File: rtl/fbs_addr_map.sv
module fbs_addr_map #(
   parameter int ADDR_W       = 8,
   parameter int COPIES       = 2,
   parameter int LO_END       = 4,
   parameter int LO_COPY_BASE = 200,
   parameter int HI_BASE      = 176,
   parameter int HI_END       = 207,
   parameter int HI_COPY_BASE = 208
) (
   input  logic [ADDR_W-1:0] index,
   output logic              guarded,
   output logic [ADDR_W-1:0] copy_base
);
   localparam int NREG = 2;

   logic [NREG-1:0]   hit;
   logic [ADDR_W-1:0] cand [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_region
      localparam int RB = (g == 0) ? 0 : HI_BASE;
      localparam int RE = (g == 0) ? LO_END : HI_END;
      localparam int RC = (g == 0) ? LO_COPY_BASE : HI_COPY_BASE;
      if (RE <= RB) begin : g_bad
         $error("fbs_addr_map: empty guarded region");
      end
      assign hit[g]  = (int'(index) >= RB) && (int'(index) < RE);
      assign cand[g] = ADDR_W'(RC + COPIES * (int'(index) - RB));
   end

   always_comb begin
      copy_base = '0;
      for (int k = 0; k < NREG; k++) begin
         if (hit[k]) copy_base = cand[k];
      end
   end

   assign guarded = |hit;

   always_comb begin
      a_r2_regions_disjoint : assert ($onehot0(hit));
   end

endmodule

// File: rtl/fbs_step_ctrl.sv
module fbs_step_ctrl
   import fbs_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int COPIES    = 2,
   parameter int MAX_INDEX = 199
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_index,
   input  logic [DATA_W-1:0] req_data,
   output logic [ADDR_W-1:0] cur_index,
   input  logic              guarded,
   input  logic [ADDR_W-1:0] copy_base,
   output logic              raw_start,
   output logic [ADDR_W-1:0] raw_addr,
   output logic [DATA_W-1:0] raw_data,
   output logic              raw_ecc_bypass,
   input  logic              raw_done,
   input  logic              raw_error,
   output logic              rsp_valid,
   output logic              rsp_error
);
   localparam int STEP_W = $clog2(COPIES + 1);

   fbs_state_e        state;
   logic [STEP_W-1:0] step;
   logic [STEP_W-1:0] last_step;
   logic [DATA_W-1:0] data_q;
   logic              err_q;
   logic              too_big;

   assign too_big   = int'(req_index) > MAX_INDEX;
   assign last_step = guarded ? STEP_W'(COPIES) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         step      <= '0;
         cur_index <= '0;
         data_q    <= '0;
         err_q     <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               cur_index <= req_index;
               data_q    <= req_data;
               step      <= '0;
               err_q     <= too_big;
               state     <= too_big ? ST_RESP : ST_ISSUE;
            end
            ST_ISSUE: state <= ST_WAIT;
            ST_WAIT: if (raw_done) begin
               if (raw_error) begin
                  err_q <= 1'b1;
                  state <= ST_RESP;
               end else if (step == last_step) begin
                  state <= ST_RESP;
               end else begin
                  step  <= step + 1'b1;
                  state <= ST_ISSUE;
               end
            end
            ST_RESP: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (state == ST_IDLE);
   assign raw_start      = (state == ST_ISSUE);
   assign rsp_valid      = (state == ST_RESP);
   assign rsp_error      = err_q;
   assign raw_data       = data_q;
   assign raw_ecc_bypass = guarded;
   assign raw_addr       = (step == last_step) ? cur_index
                                               : copy_base + ADDR_W'(step);

   a_r8_busy_after_accept : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r6_reject_at_once : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && too_big) |=> (rsp_valid && rsp_error && !raw_start));

   a_r7_abort_on_error : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && raw_done && raw_error) |=> (rsp_valid && rsp_error));

   a_r9_pulse_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r10_hold_while_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !raw_done) |=>
         ($stable(raw_addr) && $stable(raw_data) && $stable(raw_ecc_bypass)));

   a_r5_strobe_single : assert property (@(posedge clk) disable iff (!rst_n)
      raw_start |=> !raw_start);

endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int COPIES       = 2,
   parameter int MAX_INDEX    = 199,
   parameter int LO_END       = 4,
   parameter int LO_COPY_BASE = 200,
   parameter int HI_BASE      = 176,
   parameter int HI_END       = 207,
   parameter int HI_COPY_BASE = 208
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_index,
   input  logic [DATA_W-1:0] req_data,
   output logic              raw_start,
   output logic [ADDR_W-1:0] raw_addr,
   output logic [DATA_W-1:0] raw_data,
   output logic              raw_ecc_bypass,
   input  logic              raw_done,
   input  logic              raw_error,
   output logic              rsp_valid,
   output logic              rsp_error
);
   localparam int SPACE   = 1 << ADDR_W;
   localparam int TOP_HI  = (MAX_INDEX < HI_END - 1) ? MAX_INDEX : HI_END - 1;
   localparam int LAST_HI = HI_COPY_BASE + COPIES * (TOP_HI - HI_BASE) + COPIES - 1;
   localparam int LAST_LO = LO_COPY_BASE + COPIES * LO_END - 1;

   if (COPIES < 1) begin : g_chk_copies
      $error("fuse_burn_seq: COPIES must be at least 1");
   end
   if (MAX_INDEX >= SPACE) begin : g_chk_max
      $error("fuse_burn_seq: MAX_INDEX does not fit ADDR_W");
   end
   if (LAST_HI >= SPACE || LAST_LO >= SPACE) begin : g_chk_copy
      $error("fuse_burn_seq: redundancy copies exceed address space");
   end

   logic [ADDR_W-1:0] cur_index;
   logic              guarded;
   logic [ADDR_W-1:0] copy_base;

   fbs_addr_map #(
      .ADDR_W(ADDR_W), .COPIES(COPIES), .LO_END(LO_END),
      .LO_COPY_BASE(LO_COPY_BASE), .HI_BASE(HI_BASE), .HI_END(HI_END),
      .HI_COPY_BASE(HI_COPY_BASE)
   ) u_map (
      .index(cur_index), .guarded(guarded), .copy_base(copy_base)
   );

   fbs_step_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COPIES(COPIES), .MAX_INDEX(MAX_INDEX)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_index(req_index), .req_data(req_data),
      .cur_index(cur_index), .guarded(guarded), .copy_base(copy_base),
      .raw_start(raw_start), .raw_addr(raw_addr), .raw_data(raw_data),
      .raw_ecc_bypass(raw_ecc_bypass),
      .raw_done(raw_done), .raw_error(raw_error),
      .rsp_valid(rsp_valid), .rsp_error(rsp_error)
   );

   a_r2_ecc_only_main : assert property (@(posedge clk) disable iff (!rst_n)
      (raw_start && !raw_ecc_bypass) |-> (int'(raw_addr) <= MAX_INDEX));

   a_r5_copies_above_range : assert property (@(posedge clk) disable iff (!rst_n)
      (raw_start && raw_ecc_bypass && raw_addr != cur_index) |->
         (int'(raw_addr) > MAX_INDEX));

endmodule

// File: tb/fuse_burn_seq_bench.sv
module fuse_burn_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_index = '0;
   logic [31:0] req_data = '0;
   logic        raw_start;
   logic [7:0]  raw_addr;
   logic [31:0] raw_data;
   logic        raw_ecc_bypass;
   logic        raw_done = 1'b0;
   logic        raw_error = 1'b0;
   logic        rsp_valid;
   logic        rsp_error;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   fuse_burn_seq u_fuse_burn_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_index(req_index), .req_data(req_data),
      .raw_start(raw_start), .raw_addr(raw_addr), .raw_data(raw_data),
      .raw_ecc_bypass(raw_ecc_bypass),
      .raw_done(raw_done), .raw_error(raw_error),
      .rsp_valid(rsp_valid), .rsp_error(rsp_error)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit is_guarded(input int i);
      return (i < 4) || (i >= 176 && i <= 206);
   endfunction

   function automatic int first_copy(input int i);
      return (i < 4) ? 200 + 2 * i : 208 + 2 * (i - 176);
   endfunction

   // Plays the raw controller; err_step < 0 means every burn succeeds.
   task automatic run_req(input int idx, input logic [31:0] val,
                          input int err_step, input string atag);
      int     got_a [4];
      logic   got_b [4];
      logic [31:0] got_d [4];
      int     nops = 0;
      int     pend = 0;
      int     cnt = 0;
      int     done_cyc = -1;
      int     rsp_cyc = -1;
      bit     seen = 0;
      bit     ready_leak = 0;
      bit     unstable = 0;
      logic   rerr = 1'b0;
      int     exp_a [3];
      int     nexp;
      bit     exp_b;
      bit     exp_err;
      string  ntag;

      @(negedge clk);
      chk(req_ready == 1'b1, "R8", "ready before request", req_ready, 1);
      req_valid = 1'b1;
      req_index = idx[7:0];
      req_data  = val;
      @(negedge clk);
      req_index = 8'd7;          // stray request held valid while busy
      req_data  = ~val;
      while (!seen && cnt < 80) begin
         if (raw_done) begin
            raw_done  = 1'b0;
            raw_error = 1'b0;
         end
         if (req_ready) ready_leak = 1;
         if (pend > 0) begin
            if (raw_addr != got_a[(nops - 1) % 4][7:0] ||
                raw_data != got_d[(nops - 1) % 4] ||
                raw_ecc_bypass != got_b[(nops - 1) % 4]) unstable = 1;
            pend--;
            if (pend == 0) begin
               raw_done  = 1'b1;
               raw_error = (nops - 1 == err_step);
               done_cyc  = cnt;
            end
         end
         if (raw_start) begin
            if (nops < 4) begin
               got_a[nops] = int'(raw_addr);
               got_b[nops] = raw_ecc_bypass;
               got_d[nops] = raw_data;
            end
            nops++;
            pend = 2;
         end
         if (rsp_valid) begin
            seen    = 1;
            rerr    = rsp_error;
            rsp_cyc = cnt;
         end
         if (!seen) begin
            @(negedge clk);
            cnt++;
         end
      end
      req_valid = 1'b0;
      raw_done  = 1'b0;
      raw_error = 1'b0;
      chk(seen, "R9", "response seen", seen, 1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9", "response pulse width", rsp_valid, 0);
      chk(!ready_leak, "R8", "ready stayed low while busy", ready_leak, 0);
      chk(!unstable, "R10", "raw outputs held during burn", unstable, 0);

      if (idx > 199) begin
         nexp = 0; exp_err = 1; exp_b = 0; ntag = "R6";
      end else begin
         exp_b = is_guarded(idx);
         if (exp_b) begin
            exp_a[0] = first_copy(idx);
            exp_a[1] = first_copy(idx) + 1;
            exp_a[2] = idx;
            nexp = 3; ntag = "R5";
         end else begin
            exp_a[0] = idx;
            nexp = 1; ntag = "R2";
         end
         exp_err = 0;
         if (err_step >= 0) begin
            nexp = err_step + 1; exp_err = 1; ntag = "R7";
         end
      end
      chk(nops == nexp, ntag, "number of raw burns", nops, nexp);
      chk(rerr == exp_err, exp_err ? ntag : "R9", "response error flag", rerr, exp_err);
      if (idx > 199)
         chk(rsp_cyc == 0, "R6", "reject latency", rsp_cyc, 0);
      else
         chk(rsp_cyc == done_cyc + 1, "R9", "response after last done", rsp_cyc, done_cyc + 1);
      for (int k = 0; k < nexp && k < nops && k < 3; k++) begin
         chk(got_a[k] == exp_a[k], atag, "raw address", got_a[k], exp_a[k]);
         chk(got_d[k] == val, "R5", "raw data", got_d[k], val);
         chk(got_b[k] == exp_b, exp_b ? "R5" : "R2", "ecc bypass", got_b[k], exp_b);
      end
   endtask

   task automatic t_reset;
      chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      chk(raw_start == 1'b0, "R1", "no strobe after reset", raw_start, 0);
      chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);
   endtask

   task automatic t_plain;
      run_req(4,   32'h1234_5678, -1, "R2");
      run_req(100, 32'hDEAD_BEEF, -1, "R2");
      run_req(175, 32'h0000_0001, -1, "R2");
   endtask

   task automatic t_low_guarded;
      run_req(0, 32'hA5A5_A5A5, -1, "R3");
      run_req(3, 32'h0F0F_0F0F, -1, "R3");
   endtask

   task automatic t_high_guarded;
      run_req(176, 32'h8000_0000, -1, "R4");
      run_req(199, 32'hFFFF_FFFF, -1, "R4");
   endtask

   task automatic t_out_of_range;
      run_req(200, 32'h1111_1111, -1, "R6");
      run_req(255, 32'h2222_2222, -1, "R6");
   endtask

   task automatic t_errors;
      run_req(50,  32'h3333_3333, 0, "R7");
      run_req(2,   32'h4444_4444, 0, "R7");
      run_req(180, 32'h5555_5555, 1, "R7");
      run_req(1,   32'h6666_6666, 2, "R7");
      run_req(10,  32'h7777_7777, -1, "R2");  // clean run after an abort
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_low_guarded();
      t_high_guarded();
      t_out_of_range();
      t_errors();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule